// File: doc/BRIEF.md
# Cascadable Dual Interval Timer

Two 16-bit down-counting interval timers, A and B, share one small register bus. Each timer keeps a 16-bit reload value written one byte at a time and an 8-bit control register. The control register starts and stops the timer, picks continuous or one-shot operation, and holds a strobe that copies the reload value into the counter. When the count passes through zero the timer reloads, sets a sticky interrupt flag, and can drive a dedicated output pin with either a one-cycle pulse or a level that toggles.

Timer A counts either system clock cycles or rising edges of an external count input. The count input passes through two synchronizing flip-flops before its edges are detected. Timer B has four count sources: system clock cycles, rising count-input edges, Timer A underflows, or Timer A underflows that occur while the synchronized count input is high. With the last two sources the pair forms one 32-bit interval.

Each timer is a two-state machine with states STOPPED and RUNNING. It has three transitions: START (a control write with bit 0 set while STOPPED), HALT (a control write with bit 0 clear while RUNNING) and EXPIRE (an underflow in one-shot mode while RUNNING, unless a control write lands in the same cycle).

Top module: `dual_timer`

## Requirements
- R1: Control bit 0 written 1 starts the timer (START) and written 0 stops it (HALT). While the timer is stopped its counter does not change unless a load is requested.
- R2: A running timer decrements once per count tick. A tick that finds the counter at 0 is an underflow and reloads the counter from the reload latch, so a latch value L gives a period of L+1 ticks.
- R3: With control bit 3 set (one-shot), an underflow reloads the counter and clears control bit 0 (EXPIRE). With bit 3 clear the timer keeps running.
- R4: Writing a control byte with bit 4 set copies the reload latch into the counter at that write, and this load takes priority over counting. Bit 4 always reads 0, and writing bit 4 as 0 causes no load.
- R5: Each underflow sets a sticky flag: status bit 0 for A, bit 1 for B, also driven on `irq_flags`. A bus read of the status register clears both flags and returns their values from before the clear. If an underflow falls in the same cycle as the read, that flag ends up set.
- R6: Control bit 1 enables the timer's pin: `pin_x_en` follows bit 1. While bit 1 is 0 the pin output stays 0.
- R7: With bit 2 clear (pulse style), the pin is high for exactly the one clock cycle that follows each underflow.
- R8: With bit 2 set (toggle style), the pin level becomes 1 at every START and inverts at each underflow.
- R9: Timer A bit 5 selects its count source: 0 counts every clock, 1 counts rising edges of the count input after two synchronizer stages.
- R10: Timer B bits 6:5 select its source: 00 clock cycles, 01 synchronized count-input rising edges, 10 Timer A underflows, 11 Timer A underflows while the synchronized count input is high. Timer B counts an A underflow in the same cycle that A underflows.
- R11: Control bits with no function ignore writes and read 0. These are bits 7, 6 and 4 for A, and bits 7 and 4 for B, so writing 0xFF reads back 0x2F on A and 0x6F on B.
- R12: A low-byte write updates only the latch. A high-byte write updates the latch, and if the timer is stopped it also loads the counter with the full new latch value. A high-byte write while running leaves the counter counting.
- R13: The register offsets are: 0 A count/latch low, 1 A high, 2 B low, 3 B high, 4 A control, 5 B control, 6 status, 7 reads 0. Reads of 0 to 3 return the live count. After reset, counters and latches are 0xFFFF and controls, flags and pins are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (read side effects) |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| cnt_in | input | 1 | Asynchronous external count input |
| irq_flags | output | 2 | Sticky underflow flags, bit 0 A, bit 1 B |
| pin_a_en | output | 1 | Timer A owns its pin |
| pin_a | output | 1 | Timer A pin level |
| pin_b_en | output | 1 | Timer B owns its pin |
| pin_b | output | 1 | Timer B pin level |

## Verification
The case that needs care is a status read that clears the flags landing in the same clock cycle as a Timer A underflow that sets one. The bench loads a short period, counts the edges since START, and raises the read strobe so that it covers exactly the underflow edge. It then checks two things: the data read in that cycle must show the flag still clear, and the flag seen afterwards must be set. A second read one cycle later must clear it.

// File: rtl/dt_pkg.sv
`timescale 1ns/1ps
package dt_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;
    localparam int CNT_W  = 2 * DATA_W;
    localparam int HI_W   = CNT_W - DATA_W;

    typedef enum logic [0:0] {
        T_STOPPED = 1'b0,
        T_RUNNING = 1'b1
    } tmr_state_e;

    typedef struct packed {
        logic oneshot;
        logic toggle;
        logic pin_on;
    } tmr_mode_t;

    localparam logic [ADDR_W-1:0] RA_LO  = 3'd0;
    localparam logic [ADDR_W-1:0] RA_HI  = 3'd1;
    localparam logic [ADDR_W-1:0] RB_LO  = 3'd2;
    localparam logic [ADDR_W-1:0] RB_HI  = 3'd3;
    localparam logic [ADDR_W-1:0] RA_CTL = 3'd4;
    localparam logic [ADDR_W-1:0] RB_CTL = 3'd5;
    localparam logic [ADDR_W-1:0] R_STAT = 3'd6;

    localparam int CB_START = 0;
    localparam int CB_PIN   = 1;
    localparam int CB_TOG   = 2;
    localparam int CB_ONE   = 3;
    localparam int CB_LOAD  = 4;
    localparam int CB_SRC   = 5;
endpackage

// File: rtl/dt_cnt_sync.sv
`timescale 1ns/1ps
module dt_cnt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level_o,
    output logic rise_o
);
    logic [STAGES-1:0] shift_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            shift_q <= {shift_q[STAGES-2:0], async_in};
            prev_q  <= shift_q[STAGES-1];
        end
    end

    assign level_o = shift_q[STAGES-1];
    assign rise_o  = shift_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/dt_timer.sv
`timescale 1ns/1ps
module dt_timer
    import dt_pkg::*;
#(
    parameter int SRC_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_ctl,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wdata,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [CNT_W-1:0]  latch_o,
    output logic [DATA_W-1:0] ctl_o,
    output logic              uf_o,
    output logic              pin_en_o,
    output logic              pin_o
);
    tmr_state_e       state_q, state_d;
    tmr_mode_t        mode_q;
    logic [SRC_W-1:0] src_q;
    logic [CNT_W-1:0] cnt_q, latch_q;
    logic             tog_q, pulse_q;
    logic             start_evt;
    logic             unused_wbits;

    assign unused_wbits = ^wdata;
    assign uf_o      = (state_q == T_RUNNING) && tick && (cnt_q == '0);
    assign start_evt = wr_ctl && wdata[CB_START] && (state_q == T_STOPPED);

    // next-state: START, HALT, EXPIRE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            T_STOPPED: if (wr_ctl && wdata[CB_START]) state_d = T_RUNNING;
            T_RUNNING: begin
                if (wr_ctl)
                    state_d = wdata[CB_START] ? T_RUNNING : T_STOPPED;
                else if (uf_o && mode_q.oneshot)
                    state_d = T_STOPPED;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= T_STOPPED;
        else        state_q <= state_d;
    end

    // datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= '0;
            src_q   <= '0;
            cnt_q   <= '1;
            latch_q <= '1;
            tog_q   <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            if (wr_ctl) begin
                mode_q <= '{oneshot: wdata[CB_ONE], toggle: wdata[CB_TOG],
                            pin_on: wdata[CB_PIN]};
                src_q  <= wdata[CB_SRC +: SRC_W];
            end
            if (wr_lo) latch_q[DATA_W-1:0]     <= wdata;
            if (wr_hi) latch_q[CNT_W-1:DATA_W] <= wdata[HI_W-1:0];

            if (wr_ctl && wdata[CB_LOAD])
                cnt_q <= latch_q;
            else if (wr_hi && state_q == T_STOPPED)
                cnt_q <= {wdata[HI_W-1:0], latch_q[DATA_W-1:0]};
            else if (uf_o)
                cnt_q <= latch_q;
            else if (state_q == T_RUNNING && tick)
                cnt_q <= cnt_q - 1'b1;

            if (start_evt) tog_q <= 1'b1;
            else if (uf_o) tog_q <= ~tog_q;
            pulse_q <= uf_o;
        end
    end

    always_comb begin
        ctl_o                   = '0;
        ctl_o[CB_START]         = (state_q == T_RUNNING);
        ctl_o[CB_PIN]           = mode_q.pin_on;
        ctl_o[CB_TOG]           = mode_q.toggle;
        ctl_o[CB_ONE]           = mode_q.oneshot;
        ctl_o[CB_SRC +: SRC_W]  = src_q;
    end

    assign cnt_o    = cnt_q;
    assign latch_o  = latch_q;
    assign pin_en_o = mode_q.pin_on;
    assign pin_o    = mode_q.pin_on & (mode_q.toggle ? tog_q : pulse_q);
endmodule

// File: rtl/dual_timer.sv
`timescale 1ns/1ps
module dual_timer
    import dt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cnt_in,
    output logic [1:0]        irq_flags,
    output logic              pin_a_en,
    output logic              pin_a,
    output logic              pin_b_en,
    output logic              pin_b
);
    logic [CNT_W-1:0]  a_cnt, a_latch, b_cnt, b_latch;
    logic [DATA_W-1:0] a_ctl, b_ctl;
    logic              a_uf, b_uf, a_tick, b_tick;
    logic              cnt_level, cnt_rise;
    logic [1:0]        flag_q;
    logic              rd_clr;

    dt_cnt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(cnt_in),
        .level_o(cnt_level), .rise_o(cnt_rise)
    );

    assign a_tick = a_ctl[CB_SRC] ? cnt_rise : 1'b1;

    always_comb begin
        unique case (b_ctl[CB_SRC +: 2])
            2'b00: b_tick = 1'b1;
            2'b01: b_tick = cnt_rise;
            2'b10: b_tick = a_uf;
            2'b11: b_tick = a_uf & cnt_level;
        endcase
    end

    dt_timer #(.SRC_W(1)) u_tmr_a (
        .clk(clk), .rst_n(rst_n), .tick(a_tick),
        .wr_ctl(bus_wr && bus_addr == RA_CTL),
        .wr_lo (bus_wr && bus_addr == RA_LO),
        .wr_hi (bus_wr && bus_addr == RA_HI),
        .wdata(bus_wdata), .cnt_o(a_cnt), .latch_o(a_latch), .ctl_o(a_ctl),
        .uf_o(a_uf), .pin_en_o(pin_a_en), .pin_o(pin_a)
    );

    dt_timer #(.SRC_W(2)) u_tmr_b (
        .clk(clk), .rst_n(rst_n), .tick(b_tick),
        .wr_ctl(bus_wr && bus_addr == RB_CTL),
        .wr_lo (bus_wr && bus_addr == RB_LO),
        .wr_hi (bus_wr && bus_addr == RB_HI),
        .wdata(bus_wdata), .cnt_o(b_cnt), .latch_o(b_latch), .ctl_o(b_ctl),
        .uf_o(b_uf), .pin_en_o(pin_b_en), .pin_o(pin_b)
    );

    assign rd_clr = bus_rd && (bus_addr == R_STAT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= {b_uf, a_uf} | (flag_q & {2{~rd_clr}});
    end

    always_comb begin
        unique case (bus_addr)
            RA_LO:   bus_rdata = a_cnt[DATA_W-1:0];
            RA_HI:   bus_rdata = a_cnt[CNT_W-1:DATA_W];
            RB_LO:   bus_rdata = b_cnt[DATA_W-1:0];
            RB_HI:   bus_rdata = b_cnt[CNT_W-1:DATA_W];
            RA_CTL:  bus_rdata = a_ctl;
            RB_CTL:  bus_rdata = b_ctl;
            R_STAT:  bus_rdata = {{(DATA_W-2){1'b0}}, flag_q};
            default: bus_rdata = '0;
        endcase
    end

    assign irq_flags = flag_q;
endmodule

// File: rtl/dt_checker.sv
`timescale 1ns/1ps
module dt_checker
    import dt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [CNT_W-1:0]  a_cnt,
    input logic [CNT_W-1:0]  a_latch,
    input logic [CNT_W-1:0]  b_cnt,
    input logic [CNT_W-1:0]  b_latch,
    input logic [DATA_W-1:0] a_ctl,
    input logic              a_uf,
    input logic              b_uf,
    input logic [1:0]        flag_q,
    input logic              pin_a_en,
    input logic              pin_a
);
    assert_stopped_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_ctl[CB_START] && !bus_wr) |=> $stable(a_cnt));

    assert_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (a_uf && !bus_wr) |=> (a_cnt == $past(a_latch)));

    assert_oneshot_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (a_uf && a_ctl[CB_ONE] && !(bus_wr && bus_addr == RA_CTL)) |=> !a_ctl[CB_START]);

    assert_force_load_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == RA_CTL && bus_wdata[CB_LOAD])
            |=> (a_cnt == $past(a_latch) && !a_ctl[CB_LOAD]));

    assert_force_load_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == RB_CTL && bus_wdata[CB_LOAD]) |=> (b_cnt == $past(b_latch)));

    assert_flag_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
        a_uf |=> flag_q[0]);

    assert_flag_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
        b_uf |=> flag_q[1]);

    assert_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (a_uf && a_ctl[CB_PIN] && !a_ctl[CB_TOG] && !bus_wr) |=> (pin_a && pin_a_en));
endmodule

bind dual_timer dt_checker u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .a_cnt(a_cnt), .a_latch(a_latch), .b_cnt(b_cnt),
    .b_latch(b_latch), .a_ctl(a_ctl), .a_uf(a_uf), .b_uf(b_uf),
    .flag_q(flag_q), .pin_a_en(pin_a_en), .pin_a(pin_a)
);

// File: tb/dual_timer_tb_top.sv
`timescale 1ns/1ps
module dual_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0, cnt_in = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic [1:0] irq_flags;
    logic       pin_a_en, pin_a, pin_b_en, pin_b;
    int         n_chk = 0, n_fail = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    dual_timer dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt_in(cnt_in), .irq_flags(irq_flags), .pin_a_en(pin_a_en),
        .pin_a(pin_a), .pin_b_en(pin_b_en), .pin_b(pin_b)
    );

    localparam int NV = 6;
    localparam int V_LATCH [NV] = '{10, 10, 5, 0, 300, 2};
    localparam int V_TICKS [NV] = '{3, 11, 8, 4, 300, 7};
    localparam int V_COUNT [NV] = '{7, 10, 3, 0, 0, 1};
    localparam int V_FLAG  [NV] = '{0, 1, 1, 1, 0, 1};

    task automatic check(input string tag, input int got, input int exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output int v);
        bus_addr = a;
        #0.2;
        v = int'(bus_rdata);
    endtask

    task automatic peek16(input logic [2:0] lo, output int v);
        int l, h;
        peek(lo, l);
        peek(lo + 3'd1, h);
        v = (h << 8) | l;
    endtask

    task automatic rd_clr(output int v);
        bus_rd = 1'b1; bus_addr = 3'd6;
        #0.2;
        v = int'(bus_rdata);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int v, s, pin_seen;
        step(3);
        rst_n = 1'b1;
        step(1);

        // R13 reset state
        peek16(3'd0, v);  check("R13 A count reset", v, 16'hFFFF);
        peek16(3'd2, v);  check("R13 B count reset", v, 16'hFFFF);
        peek(3'd4, v);    check("R13 A ctl reset", v, 0);
        peek(3'd6, v);    check("R13 status reset", v, 0);
        peek(3'd7, v);    check("R13 unmapped offset", v, 0);
        check("R13 pins reset", {pin_a_en, pin_a, pin_b_en, pin_b, irq_flags}, 0);

        // R2 vector table: continuous counting from clock
        for (int i = 0; i < NV; i++) begin
            wr(3'd4, 8'h00);
            rd_clr(v);
            wr(3'd0, 8'(V_LATCH[i]));
            wr(3'd1, 8'(V_LATCH[i] >> 8));
            wr(3'd4, 8'h01);
            step(V_TICKS[i]);
            peek16(3'd0, v);  check("R2 count after ticks", v, V_COUNT[i]);
            peek(3'd6, v);    check("R2 R5 flag after ticks", v & 1, V_FLAG[i]);
        end

        // R3 one-shot
        wr(3'd4, 8'h00); rd_clr(v);
        wr(3'd0, 8'd3); wr(3'd1, 8'd0);
        wr(3'd4, 8'h09);
        step(3);
        peek16(3'd0, v);  check("R3 one-shot mid count", v, 0);
        peek(3'd4, v);    check("R3 still running", v, 8'h09);
        step(3);
        peek16(3'd0, v);  check("R3 reloaded after expire", v, 3);
        peek(3'd4, v);    check("R3 R1 start cleared", v, 8'h08);
        peek(3'd6, v);    check("R5 one-shot flag", v & 1, 1);

        // R4 force load strobe
        wr(3'd4, 8'h00);
        wr(3'd0, 8'h00); wr(3'd1, 8'h01);
        wr(3'd4, 8'h01);
        step(10);
        peek16(3'd0, v);  check("R4 before load", v, 16'h00F6);
        wr(3'd4, 8'h11);
        peek16(3'd0, v);  check("R4 force load", v, 16'h0100);
        peek(3'd4, v);    check("R4 strobe reads 0", v, 8'h01);
        wr(3'd4, 8'h01);
        peek16(3'd0, v);  check("R4 bit4=0 no load", v, 16'h00FF);
        wr(3'd4, 8'h00);
        peek16(3'd0, s);
        step(5);
        peek16(3'd0, v);  check("R1 stopped holds", v, s);

        // R12 latch byte writes
        wr(3'd0, 8'h34);
        peek16(3'd0, v);  check("R12 low write no load", v, s);
        wr(3'd1, 8'h12);
        peek16(3'd0, v);  check("R12 high write loads when stopped", v, 16'h1234);
        wr(3'd4, 8'h01);
        step(2);
        wr(3'd1, 8'h56);
        peek16(3'd0, v);  check("R12 high write while running", v, 16'h1231);
        wr(3'd4, 8'h11);
        peek16(3'd0, v);  check("R12 latch holds new high byte", v, 16'h5634);

        // R11 unused bits
        wr(3'd4, 8'hFF);
        peek(3'd4, v);    check("R11 A unused bits", v, 8'h2F);
        wr(3'd5, 8'hFF);
        peek(3'd5, v);    check("R11 B unused bits", v, 8'h6F);
        wr(3'd4, 8'h00); wr(3'd5, 8'h00);

        // R6 R7 pulse pin
        wr(3'd0, 8'd2); wr(3'd1, 8'd0);
        check("R6 pin off when disabled", {pin_a_en, pin_a}, 0);
        wr(3'd4, 8'h03);
        check("R6 pin enable", pin_a_en, 1);
        step(2);
        check("R7 pulse low before underflow", pin_a, 0);
        step(1);
        check("R7 pulse high after underflow", pin_a, 1);
        step(1);
        check("R7 pulse one cycle", pin_a, 0);
        wr(3'd4, 8'h01);
        pin_seen = 0;
        for (int k = 0; k < 6; k++) begin
            step(1);
            pin_seen |= pin_a;
        end
        check("R6 pin quiet when disabled", {pin_a_en, 1'(pin_seen)}, 0);

        // R8 toggle pin
        wr(3'd4, 8'h00);
        wr(3'd0, 8'd1); wr(3'd1, 8'd0);
        wr(3'd4, 8'h07);
        check("R8 toggle set on start", pin_a, 1);
        step(1);
        check("R8 toggle before underflow", pin_a, 1);
        step(1);
        check("R8 toggle first underflow", pin_a, 0);
        step(2);
        check("R8 toggle second underflow", pin_a, 1);

        // R9 Timer A counting CNT edges
        wr(3'd4, 8'h00);
        wr(3'd0, 8'd5); wr(3'd1, 8'd0);
        wr(3'd4, 8'h21);
        step(10);
        peek16(3'd0, v);  check("R9 no edges no count", v, 5);
        for (int k = 0; k < 3; k++) begin
            cnt_in = 1'b1; step(4);
            cnt_in = 1'b0; step(4);
        end
        step(4);
        peek16(3'd0, v);  check("R9 three CNT edges", v, 2);

        // R10 Timer B cascaded from A
        wr(3'd4, 8'h00);
        wr(3'd2, 8'd100); wr(3'd3, 8'd0);
        wr(3'd0, 8'd1); wr(3'd1, 8'd0);
        wr(3'd5, 8'h41);
        step(5);
        peek16(3'd2, v);  check("R10 B ignores clock in cascade", v, 100);
        wr(3'd4, 8'h01);
        step(10);
        peek16(3'd2, v);  check("R10 B counts A underflows", v, 95);
        wr(3'd5, 8'h61);
        peek16(3'd2, s);
        step(10);
        peek16(3'd2, v);  check("R10 gated B holds while CNT low", v, s);
        cnt_in = 1'b1; step(5);
        peek16(3'd2, s);
        step(10);
        peek16(3'd2, v);  check("R10 gated B counts while CNT high", v, s - 5);
        wr(3'd4, 8'h00);
        wr(3'd5, 8'h21);
        cnt_in = 1'b0; step(5);
        peek16(3'd2, s);
        for (int k = 0; k < 2; k++) begin
            cnt_in = 1'b1; step(4);
            cnt_in = 1'b0; step(4);
        end
        peek16(3'd2, v);  check("R10 B counts CNT edges", v, s - 2);
        wr(3'd5, 8'h00);
        wr(3'd3, 8'd0); wr(3'd2, 8'd4); wr(3'd3, 8'd0);
        rd_clr(v);
        wr(3'd5, 8'h01);
        step(5);
        peek(3'd6, v);    check("R10 R5 B clock-mode flag", v, 2);

        // R5 status read in the same cycle as an underflow
        wr(3'd5, 8'h00);
        rd_clr(v);
        wr(3'd0, 8'd3); wr(3'd1, 8'd0);
        wr(3'd4, 8'h01);
        step(3);
        rd_clr(v);        check("R5 read value at underflow edge", v & 1, 0);
        check("R5 set wins over clear", irq_flags[0], 1);
        rd_clr(v);        check("R5 read returns set flag", v & 1, 1);
        peek(3'd6, v);    check("R5 read clears flag", v & 1, 0);
        wr(3'd4, 8'h00);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule